// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Dot-Product Mode

This block is a pipelined arithmetic step for filter and transform kernels. Each valid input pair of 18-bit operands goes through a multiplier, and the product is combined with a 44-bit running value. The combination can add the product to the running value, subtract it, or start a new sum from the product alone. A two-bit mode input selects how the operands are multiplied. The choices are a signed 18x18 product, an unsigned product of the low 17 bits of each operand, or a dot-product form.

In the dot-product form each operand is split into a low and a high 9-bit field, both treated as unsigned. The unit multiplies the low field of one operand by the high field of the other, adds the two cross terms, and scales the sum by 2^9. Products are extended to 44 bits before the add/subtract stage. Signed products are sign-extended and the other forms are zero-extended. The running value wraps modulo 2^44.

The pipeline has two registers: a product register, then the accumulator register. A result appears two cycles after its input is accepted.

Top module: `mac_dot_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_valid` is 0 and `result` is 0.
- R2: `out_valid` is high exactly two clock cycles after `in_valid` was high, with no other latency, and results come out in input order at one per cycle.
- R3: Mode code 0 gives the signed product `a*b` (18x18, two's complement), sign-extended to 44 bits.
- R4: Mode code 1 gives the unsigned product `a[16:0]*b[16:0]`, zero-extended. Bit 17 of either operand has no effect.
- R5: Mode code 2 gives `(a[8:0]*b[17:9] + a[17:9]*b[8:0]) << 9`, with every 9-bit field treated as unsigned, zero-extended.
- R6: Mode code 3 gives a product of zero.
- R7: With `clr`=0 and `sub`=0, the new result is the previous result plus the product.
- R8: With `clr`=0 and `sub`=1, the new result is the previous result minus the product.
- R9: With `clr`=1, the previous result is discarded. The new result is the product (`sub`=0) or its negation (`sub`=1).
- R10: All accumulation is modulo 2^44, with no saturation or overflow flag.
- R11: A cycle with `in_valid` low changes nothing. `result` holds its value whenever `out_valid` is low, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are accepted this cycle |
| a | input | 18 | First operand |
| b | input | 18 | Second operand |
| mode | input | 2 | 0 signed, 1 unsigned 17-bit, 2 dot product, 3 zero |
| sub | input | 1 | Subtract the product instead of adding it |
| clr | input | 1 | Start a new sum from this product |
| result | output | 44 | Running accumulator value |
| out_valid | output | 1 | `result` was updated on the last edge |

## Verification
The checker assumes that inputs are stable and known around each rising edge. It assumes that `rst` is high for at least one edge before operation starts. It also assumes that `mode`, `sub` and `clr` matter only in cycles where `in_valid` is high. Its properties that look two cycles back are gated by a counter of edges since reset, so they never see the cycles before the first clear.

The bench changes inputs only on falling edges and keeps `in_valid` low during reset. In idle cycles it deliberately puts arbitrary values on the operands and controls, which exercises the ignore rule without breaking the checker's assumptions.

// File: rtl/mac_dot_pkg.sv
package mac_dot_pkg;

  typedef enum logic [1:0] {
    MUL_SIGNED   = 2'd0,
    MUL_UNSIGNED = 2'd1,
    MUL_DOT      = 2'd2,
    MUL_NONE     = 2'd3
  } mul_mode_e;

  // Controls travelling with a product through the pipeline
  typedef struct packed {
    logic vld;
    logic sub;
    logic clr;
  } pipe_ctl_t;

endpackage

// File: rtl/mac_mult.sv
module mac_mult
  import mac_dot_pkg::*;
#(
  parameter int OP_W  = 18,
  parameter int ACC_W = 44
) (
  input  logic [OP_W-1:0]  a,
  input  logic [OP_W-1:0]  b,
  input  mul_mode_e        mode,
  output logic [ACC_W-1:0] prod
);
  localparam int HALF_W  = OP_W / 2;
  localparam int UNS_W   = OP_W - 1;
  localparam int PROD_W  = 2 * OP_W;
  localparam int UPROD_W = 2 * UNS_W;
  localparam int HPROD_W = 2 * HALF_W;
  localparam int DSUM_W  = HPROD_W + 1;

  logic signed [PROD_W-1:0] s_prod;
  logic [UPROD_W-1:0]       u_prod;
  logic [HPROD_W-1:0]       cross_lh, cross_hl;
  logic [DSUM_W-1:0]        dot_sum;
  logic [ACC_W-1:0]         s_ext, u_ext, d_ext;

  // Full signed product on sign-extended operands
  assign s_prod = $signed({{OP_W{a[OP_W-1]}}, a}) * $signed({{OP_W{b[OP_W-1]}}, b});

  // Unsigned product of the low bits only
  assign u_prod = {{UNS_W{1'b0}}, a[UNS_W-1:0]} * {{UNS_W{1'b0}}, b[UNS_W-1:0]};

  // Cross terms of unsigned half fields
  assign cross_lh = {{HALF_W{1'b0}}, a[HALF_W-1:0]} * {{HALF_W{1'b0}}, b[OP_W-1:HALF_W]};
  assign cross_hl = {{HALF_W{1'b0}}, a[OP_W-1:HALF_W]} * {{HALF_W{1'b0}}, b[HALF_W-1:0]};
  assign dot_sum  = {1'b0, cross_lh} + {1'b0, cross_hl};

  assign s_ext = {{(ACC_W-PROD_W){s_prod[PROD_W-1]}}, s_prod};
  assign u_ext = {{(ACC_W-UPROD_W){1'b0}}, u_prod};
  assign d_ext = {{(ACC_W-DSUM_W-HALF_W){1'b0}}, dot_sum, {HALF_W{1'b0}}};

  always_comb begin
    unique case (mode)
      MUL_SIGNED:   prod = s_ext;
      MUL_UNSIGNED: prod = u_ext;
      MUL_DOT:      prod = d_ext;
      default:      prod = '0;
    endcase
  end
endmodule

// File: rtl/mac_prod_stage.sv
module mac_prod_stage
  import mac_dot_pkg::*;
#(
  parameter int ACC_W = 44
) (
  input  logic             clk,
  input  logic             rst,
  input  pipe_ctl_t        ctl_in,
  input  logic [ACC_W-1:0] prod_in,
  output pipe_ctl_t        ctl_q,
  output logic [ACC_W-1:0] prod_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      prod_q <= '0;
    end else begin
      ctl_q <= ctl_in;
      if (ctl_in.vld) prod_q <= prod_in;
    end
  end
endmodule

// File: rtl/mac_acc_stage.sv
module mac_acc_stage
  import mac_dot_pkg::*;
#(
  parameter int ACC_W = 44
) (
  input  logic             clk,
  input  logic             rst,
  input  pipe_ctl_t        ctl,
  input  logic [ACC_W-1:0] prod,
  output logic [ACC_W-1:0] acc_q,
  output logic             vld_q
);
  logic [ACC_W-1:0] base;
  logic [ACC_W-1:0] next_acc;

  assign base     = ctl.clr ? '0 : acc_q;
  assign next_acc = ctl.sub ? (base - prod) : (base + prod);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= ctl.vld;
      if (ctl.vld) acc_q <= next_acc;
    end
  end
endmodule

// File: rtl/mac_dot_unit.sv
module mac_dot_unit
  import mac_dot_pkg::*;
#(
  parameter int OP_W  = 18,
  parameter int ACC_W = 44
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  a,
  input  logic [OP_W-1:0]  b,
  input  logic [1:0]       mode,
  input  logic             sub,
  input  logic             clr,
  output logic [ACC_W-1:0] result,
  output logic             out_valid
);
  logic [ACC_W-1:0] prod_c, prod_r;
  pipe_ctl_t        ctl_c, ctl_r;

  assign ctl_c = '{vld: in_valid, sub: sub, clr: clr};

  mac_mult #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mult (
    .a(a), .b(b), .mode(mul_mode_e'(mode)), .prod(prod_c)
  );

  mac_prod_stage #(.ACC_W(ACC_W)) u_pstage (
    .clk(clk), .rst(rst), .ctl_in(ctl_c), .prod_in(prod_c),
    .ctl_q(ctl_r), .prod_q(prod_r)
  );

  mac_acc_stage #(.ACC_W(ACC_W)) u_astage (
    .clk(clk), .rst(rst), .ctl(ctl_r), .prod(prod_r),
    .acc_q(result), .vld_q(out_valid)
  );
endmodule

// File: rtl/mac_dot_checker.sv
module mac_dot_checker #(
  parameter int OP_W  = 18,
  parameter int ACC_W = 44
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [OP_W-1:0]  a,
  input logic [OP_W-1:0]  b,
  input logic [1:0]       mode,
  input logic             sub,
  input logic             clr,
  input logic [ACC_W-1:0] result,
  input logic             out_valid
);
  localparam int H = OP_W / 2;
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0)); // R1

  AST_TWO_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2))); // R2

  AST_SIGNED_LOAD: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && $past(in_valid && clr && !sub && mode == 2'd0, 2)) |->
    ($signed(result) == ACC_W'($signed($past(a, 2)) * $signed($past(b, 2))))); // R3

  AST_UNSIGNED_LOAD: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && $past(in_valid && clr && !sub && mode == 2'd1, 2)) |->
    (result == ACC_W'(ACC_W'($past(a[OP_W-2:0], 2)) * ACC_W'($past(b[OP_W-2:0], 2))))); // R4

  AST_DOT_LOAD: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && $past(in_valid && clr && !sub && mode == 2'd2, 2)) |->
    (result == ((ACC_W'($past(a[H-1:0], 2)) * ACC_W'($past(b[OP_W-1:H], 2)) +
                 ACC_W'($past(a[OP_W-1:H], 2)) * ACC_W'($past(b[H-1:0], 2))) << H))); // R5

  AST_SIGNED_ACCUM: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && $past(in_valid && !clr && !sub && mode == 2'd0, 2)) |->
    (result == $past(result) + ACC_W'($signed($past(a, 2)) * $signed($past(b, 2))))); // R7

  AST_ZERO_MODE_SUB: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && $past(in_valid && !clr && mode == 2'd3, 2)) |->
    (result == $past(result))); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd1 && !out_valid) |-> $stable(result)); // R11
endmodule

bind mac_dot_unit mac_dot_checker #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mac_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .a(a), .b(b), .mode(mode),
  .sub(sub), .clr(clr), .result(result), .out_valid(out_valid)
);

// File: tb/tb_mac_dot_unit.sv
module tb_mac_dot_unit;
  localparam int OP_W  = 18;
  localparam int ACC_W = 44;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [OP_W-1:0]  a = '0, b = '0;
  logic [1:0]       mode = '0;
  logic             sub = 1'b0, clr = 1'b0;
  logic [ACC_W-1:0] result;
  logic             out_valid;

  int checks = 0;
  int fails  = 0;
  logic [ACC_W-1:0] model = '0;

  always #2.5 clk = ~clk;

  mac_dot_unit #(.OP_W(OP_W), .ACC_W(ACC_W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a(a), .b(b), .mode(mode),
    .sub(sub), .clr(clr), .result(result), .out_valid(out_valid)
  );

  function automatic logic [ACC_W-1:0] ref_prod(input logic [17:0] x, input logic [17:0] y,
                                                input logic [1:0] m);
    logic signed [ACC_W-1:0] sx, sy;
    logic [ACC_W-1:0] t1, t2;
    sx = {{(ACC_W-18){x[17]}}, x};
    sy = {{(ACC_W-18){y[17]}}, y};
    case (m)
      2'd0: return sx * sy;
      2'd1: return ACC_W'(x[16:0]) * ACC_W'(y[16:0]);
      2'd2: begin
        t1 = ACC_W'(x[8:0]) * ACC_W'(y[17:9]);
        t2 = ACC_W'(x[17:9]) * ACC_W'(y[8:0]);
        return (t1 + t2) << 9;
      end
      default: return '0;
    endcase
  endfunction

  function automatic logic [ACC_W-1:0] ref_step(input logic [ACC_W-1:0] acc,
                                                input logic [ACC_W-1:0] p,
                                                input logic s, input logic c);
    logic [ACC_W-1:0] base;
    base = c ? '0 : acc;
    return s ? base - p : base + p;
  endfunction

  task automatic check(input string req, input logic [ACC_W-1:0] act, input logic [ACC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One operation: drive on a falling edge, check two edges later
  task automatic do_op(input string req, input logic [17:0] x, input logic [17:0] y,
                       input logic [1:0] m, input logic s, input logic c);
    @(negedge clk);
    a = x; b = y; mode = m; sub = s; clr = c; in_valid = 1'b1;
    model = ref_step(model, ref_prod(x, y, m), s, c);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, "/R2 early valid"}, ACC_W'(out_valid), '0);
    @(negedge clk);
    check({req, "/R2 valid"}, ACC_W'(out_valid), 1);
    check(req, result, model);
  endtask

  task automatic t_reset;
    check("R1 valid", ACC_W'(out_valid), '0);
    check("R1 result", result, '0);
  endtask

  task automatic t_modes;
    do_op("R3 signed pos*neg", 18'h00123, 18'h3FF00, 2'd0, 1'b0, 1'b1);
    do_op("R3 signed neg*neg", 18'h20000, 18'h20000, 2'd0, 1'b0, 1'b1);
    check("R3 max square", result, 44'h004_0000_0000);
    do_op("R4 unsigned top bits", 18'h3FFFF, 18'h3FFFF, 2'd1, 1'b0, 1'b1);
    check("R4 const", result, 44'h3_FFFC_0001);
    do_op("R5 dot small", {9'd3, 9'd5}, {9'd7, 9'd11}, 2'd2, 1'b0, 1'b1);
    check("R5 const", result, 44'd34816);
    do_op("R5 dot all ones", 18'h3FFFF, 18'h3FFFF, 2'd2, 1'b0, 1'b1);
    do_op("R6 zero mode", 18'h12345, 18'h0ABCD, 2'd3, 1'b0, 1'b0);
  endtask

  task automatic t_accumulate;
    do_op("R9 load", 18'd1000, 18'd2000, 2'd0, 1'b0, 1'b1);
    do_op("R7 add", 18'd300, 18'h3FFFD, 2'd0, 1'b0, 1'b0);
    do_op("R8 subtract", 18'd77, 18'd99, 2'd1, 1'b1, 1'b0);
    do_op("R7 add dot", {9'd100, 9'd200}, {9'd300, 9'd400}, 2'd2, 1'b0, 1'b0);
    do_op("R9 load negated", 18'd5, 18'd6, 2'd0, 1'b1, 1'b1);
    check("R9 const", result, 44'hFFF_FFFF_FFE2);
  endtask

  task automatic t_wrap;
    do_op("R10 below zero", 18'h1FFFF, 18'h1FFFF, 2'd0, 1'b1, 1'b1);
    do_op("R10 wrap up", 18'h1FFFF, 18'h1FFFF, 2'd0, 1'b0, 1'b0);
    do_op("R10 wrap again", 18'h1FFFF, 18'h1FFFF, 2'd0, 1'b0, 1'b0);
    check("R10 const", result, 44'h3_FFFC_0001);
  endtask

  task automatic t_idle;
    logic [ACC_W-1:0] held;
    held = result;
    @(negedge clk);
    a = 18'h2AAAA; b = 18'h15555; mode = 2'd0; sub = 1'b1; clr = 1'b1; in_valid = 1'b0;
    repeat (4) @(negedge clk);
    check("R11 no valid", ACC_W'(out_valid), '0);
    check("R11 held", result, held);
  endtask

  task automatic t_stream;
    logic [ACC_W-1:0] exp_q [4];
    logic [17:0] xs [4];
    logic [1:0]  ms [4];
    xs = '{18'd11, 18'h3FFF0, 18'h2F0F0, 18'd9};
    ms = '{2'd0, 2'd1, 2'd2, 2'd0};
    for (int i = 0; i < 4; i++) begin
      model = ref_step(model, ref_prod(xs[i], 18'd513, ms[i]), i[0], i == 0);
      exp_q[i] = model;
    end
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      if (j >= 2) begin
        check("R2 stream valid", ACC_W'(out_valid), 1);
        check("R2 stream order", result, exp_q[j-2]);
      end
      if (j < 4) begin
        a = xs[j]; b = 18'd513; mode = ms[j]; sub = j[0]; clr = (j == 0); in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    check("R2 stream end", ACC_W'(out_valid), '0);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_modes();
    t_accumulate();
    t_wrap();
    t_idle();
    t_stream();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule